// File: doc/BRIEF.md
# Sliding Memory Aperture Translator

This block sits on a device's register-space bus and gives a host a way to reach a large backing memory before any page-table translation has been set up. A fixed 1 MB window in register space is mapped onto a movable region of a 40-bit physical memory space. A control register sets where that region starts and which memory target it reaches. The start is any 64 KB boundary, and the target is video memory, coherent system memory or non-coherent system memory.

Each host access is decoded when it is accepted. Accesses to the control register are served inside the block. Accesses that fall inside the window are translated and sent to the memory-side port, along with the target selector. Every other access goes unchanged to the default slave port. A read returns its data from whichever port served it. Only one host access is outstanding at a time.

The sequencer has seven states:
- `S_IDLE`: ready for a new access.
- `S_CTRL`: control register access.
- `S_MEM_REQ` and `S_MEM_WAIT`: memory request issued, then its response awaited.
- `S_DEF_REQ` and `S_DEF_WAIT`: the same pair for the default slave.
- `S_RESP`: host response.

It has these transitions:
- `S_IDLE`→`S_CTRL`, `S_IDLE`→`S_MEM_REQ` and `S_IDLE`→`S_DEF_REQ` when an access is accepted, chosen by the decoded destination.
- `S_MEM_REQ`→`S_MEM_WAIT` on `m_ready`.
- `S_MEM_WAIT`→`S_RESP` on `m_rvalid`.
- `S_DEF_REQ`→`S_DEF_WAIT` on `s_ready`.
- `S_DEF_WAIT`→`S_RESP` on `s_rvalid`.
- `S_CTRL`→`S_RESP` unconditionally.
- `S_RESP`→`S_IDLE` unconditionally.

Top module: `aperture_xlate`

## Requirements
- R1: After reset the control register reads 0, meaning video memory at base 0. `h_ready` is 1 and neither `m_valid` nor `s_valid` is asserted.
- R2: Host word addresses 0x700000 to 0x7FFFFF go to the memory port. Every other address except the control register goes to the default port with its address unchanged. 0x6FFFFC and 0x800000 go to the default port.
- R3: The memory address is (base << 16) + (host address bits 19:0), taken modulo 2^40. Base values up to 0xFFFFFF work, and the sum wraps at the top of the space.
- R4: `m_target` carries control bits 25:24, where 0 is video, 1 is coherent system and 2 is non-coherent system memory. A memory request never shows 3.
- R5: A control write whose bits 25:24 are 3 updates the base but leaves the target as it was.
- R6: The control register is at host address 0x001700. It reads back as {6'b0, target[1:0], base[23:0]}, so bits 31:26 always read 0. A write changes only the bytes whose byte enables are set.
- R7: Write data and byte enables reach the serving port unchanged. Read data comes back from the port that served the access.
- R8: Only one host access is outstanding. `h_ready` stays 0 from acceptance until the response cycle has passed.
- R9: A request held against a low ready keeps its address, target, data and byte enables stable.
- R10: A new control value applies to every access accepted after the control write's response.
- R11: A control register access makes no request on either port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_valid | input | 1 | Host access request |
| h_ready | output | 1 | Host access accepted when high together with `h_valid` |
| h_write | input | 1 | 1 for a write, 0 for a read |
| h_addr | input | 24 | Host register-space byte address |
| h_wdata | input | 32 | Host write data |
| h_be | input | 4 | Host byte enables |
| h_rvalid | output | 1 | One-cycle response strobe, for reads and writes |
| h_rdata | output | 32 | Read data, valid with `h_rvalid` |
| m_valid | output | 1 | Memory-side request |
| m_ready | input | 1 | Memory-side request accepted |
| m_write | output | 1 | Memory-side write flag |
| m_addr | output | 40 | Translated physical address |
| m_target | output | 2 | Memory target selector |
| m_wdata | output | 32 | Memory-side write data |
| m_be | output | 4 | Memory-side byte enables |
| m_rvalid | input | 1 | Memory-side response strobe |
| m_rdata | input | 32 | Memory-side read data |
| s_valid | output | 1 | Default slave request |
| s_ready | input | 1 | Default slave request accepted |
| s_write | output | 1 | Default slave write flag |
| s_addr | output | 24 | Default slave address |
| s_wdata | output | 32 | Default slave write data |
| s_be | output | 4 | Default slave byte enables |
| s_rvalid | input | 1 | Default slave response strobe |
| s_rdata | input | 32 | Default slave read data |

## Verification
The assertions check on every cycle that:
- at most one port is requesting;
- `h_ready` stays low while anything is in flight;
- a stalled request holds its fields;
- no memory request carries target 3;
- the low 16 address bits and the default-port address follow the accepted host address.

Only the bench's scenarios can show:
- the full translation at several bases, including the highest base and wrap-around;
- target retention on a write of 3;
- byte-enable merging and zero readback of unused control bits;
- data integrity against a reference memory;
- that a control access reaches no port.

// File: rtl/ap_pkg.sv
package ap_pkg;

    typedef enum logic [1:0] {
        TGT_VID  = 2'd0,
        TGT_COH  = 2'd1,
        TGT_NCOH = 2'd2,
        TGT_RSVD = 2'd3
    } tgt_e;

    typedef enum logic [1:0] {
        DST_CTRL = 2'd0,
        DST_MEM  = 2'd1,
        DST_DEF  = 2'd2
    } dst_e;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_CTRL     = 3'd1,
        S_MEM_REQ  = 3'd2,
        S_MEM_WAIT = 3'd3,
        S_DEF_REQ  = 3'd4,
        S_DEF_WAIT = 3'd5,
        S_RESP     = 3'd6
    } state_e;

endpackage

// File: rtl/ap_ctrl_reg.sv
module ap_ctrl_reg
    import ap_pkg::*;
#(
    parameter int BASE_W = 24,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DW-1:0]     wdata,
    input  logic [DW/8-1:0]   be,
    output logic [BASE_W-1:0] base,
    output tgt_e              tgt,
    output logic [DW-1:0]     rdata
);
    localparam int NB = DW / 8;

    logic [BASE_W-1:0] base_q;
    tgt_e              tgt_q;
    logic [DW-1:0]     cur_word;
    logic [DW-1:0]     mrg_word;
    logic [1:0]        new_tgt;

    // current value as seen by software; unused bits stay zero
    always_comb begin
        cur_word               = '0;
        cur_word[BASE_W-1:0]   = base_q;
        cur_word[BASE_W +: 2]  = tgt_q;
    end

    // byte-lane merge of the write data over the current value
    always_comb begin
        for (int b = 0; b < NB; b++) begin
            mrg_word[b*8 +: 8] = be[b] ? wdata[b*8 +: 8] : cur_word[b*8 +: 8];
        end
        new_tgt = mrg_word[BASE_W +: 2];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            tgt_q  <= TGT_VID;
        end else if (we) begin
            base_q <= mrg_word[BASE_W-1:0];
            if (new_tgt != 2'd3) begin
                tgt_q <= tgt_e'(new_tgt);
            end
        end
    end

    assign base  = base_q;
    assign tgt   = tgt_q;
    assign rdata = cur_word;

endmodule

// File: rtl/ap_decode.sv
module ap_decode
    import ap_pkg::*;
#(
    parameter int               HADDR_W   = 24,
    parameter int               MADDR_W   = 40,
    parameter int               GRAN_LOG2 = 16,
    parameter int               WIN_LOG2  = 20,
    parameter logic [23:0]      WIN_BASE  = 24'h700000,
    parameter logic [23:0]      CTRL_ADDR = 24'h001700
) (
    input  logic [HADDR_W-1:0]            addr,
    input  logic [MADDR_W-GRAN_LOG2-1:0]  base,
    output dst_e                          dst,
    output logic [MADDR_W-1:0]            xaddr
);
    localparam int BASE_W = MADDR_W - GRAN_LOG2;

    logic in_win;
    logic is_ctrl;

    assign in_win  = (addr[HADDR_W-1:WIN_LOG2] == WIN_BASE[HADDR_W-1:WIN_LOG2]);
    assign is_ctrl = (addr[HADDR_W-1:2] == CTRL_ADDR[HADDR_W-1:2]);

    always_comb begin
        if (is_ctrl)     dst = DST_CTRL;
        else if (in_win) dst = DST_MEM;
        else             dst = DST_DEF;
    end

    // 64 KB granular base plus 1 MB window offset, wrapping at the top
    assign xaddr = {base, {GRAN_LOG2{1'b0}}}
                 + {{(MADDR_W-WIN_LOG2){1'b0}}, addr[WIN_LOG2-1:0]};

    logic unused_ok;
    assign unused_ok = ^{BASE_W};

endmodule

// File: rtl/ap_fsm.sv
module ap_fsm
    import ap_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   h_valid,
    input  dst_e   dst,
    input  logic   m_ready,
    input  logic   m_rvalid,
    input  logic   s_ready,
    input  logic   s_rvalid,
    output logic   h_ready,
    output logic   accept,
    output logic   ctrl_go,
    output logic   m_valid,
    output logic   s_valid,
    output logic   cap_m,
    output logic   cap_s,
    output logic   h_rvalid
);
    state_e state, state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE: begin
                if (h_valid) begin
                    unique case (dst)
                        DST_CTRL: state_nxt = S_CTRL;
                        DST_MEM:  state_nxt = S_MEM_REQ;
                        default:  state_nxt = S_DEF_REQ;
                    endcase
                end
            end
            S_CTRL:     state_nxt = S_RESP;
            S_MEM_REQ:  if (m_ready)  state_nxt = S_MEM_WAIT;
            S_MEM_WAIT: if (m_rvalid) state_nxt = S_RESP;
            S_DEF_REQ:  if (s_ready)  state_nxt = S_DEF_WAIT;
            S_DEF_WAIT: if (s_rvalid) state_nxt = S_RESP;
            S_RESP:     state_nxt = S_IDLE;
            default:    state_nxt = S_IDLE;
        endcase
    end

    always_comb begin
        h_ready  = (state == S_IDLE);
        accept   = (state == S_IDLE) && h_valid;
        ctrl_go  = (state == S_CTRL);
        m_valid  = (state == S_MEM_REQ);
        s_valid  = (state == S_DEF_REQ);
        cap_m    = (state == S_MEM_WAIT) && m_rvalid;
        cap_s    = (state == S_DEF_WAIT) && s_rvalid;
        h_rvalid = (state == S_RESP);
    end

endmodule

// File: rtl/aperture_xlate.sv
module aperture_xlate
    import ap_pkg::*;
#(
    parameter int          HADDR_W   = 24,
    parameter int          MADDR_W   = 40,
    parameter int          DW        = 32,
    parameter int          GRAN_LOG2 = 16,
    parameter int          WIN_LOG2  = 20,
    parameter logic [23:0] WIN_BASE  = 24'h700000,
    parameter logic [23:0] CTRL_ADDR = 24'h001700
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               h_valid,
    output logic               h_ready,
    input  logic               h_write,
    input  logic [HADDR_W-1:0] h_addr,
    input  logic [DW-1:0]      h_wdata,
    input  logic [DW/8-1:0]    h_be,
    output logic               h_rvalid,
    output logic [DW-1:0]      h_rdata,
    output logic               m_valid,
    input  logic               m_ready,
    output logic               m_write,
    output logic [MADDR_W-1:0] m_addr,
    output logic [1:0]         m_target,
    output logic [DW-1:0]      m_wdata,
    output logic [DW/8-1:0]    m_be,
    input  logic               m_rvalid,
    input  logic [DW-1:0]      m_rdata,
    output logic               s_valid,
    input  logic               s_ready,
    output logic               s_write,
    output logic [HADDR_W-1:0] s_addr,
    output logic [DW-1:0]      s_wdata,
    output logic [DW/8-1:0]    s_be,
    input  logic               s_rvalid,
    input  logic [DW-1:0]      s_rdata
);
    localparam int BASE_W = MADDR_W - GRAN_LOG2;
    localparam int NB     = DW / 8;

    logic [BASE_W-1:0]  cfg_base;
    tgt_e               cfg_tgt;
    logic [DW-1:0]      cfg_rdata;
    dst_e               dec_dst;
    logic [MADDR_W-1:0] dec_xaddr;
    logic               accept, ctrl_go, cap_m, cap_s;

    // captured access: translation frozen at acceptance
    logic               q_write;
    logic [HADDR_W-1:0] q_haddr;
    logic [MADDR_W-1:0] q_xaddr;
    tgt_e               q_tgt;
    logic [DW-1:0]      q_wdata;
    logic [NB-1:0]      q_be;
    logic [DW-1:0]      rsp_q;

    ap_ctrl_reg #(.BASE_W(BASE_W), .DW(DW)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctrl_go && q_write),
        .wdata (q_wdata),
        .be    (q_be),
        .base  (cfg_base),
        .tgt   (cfg_tgt),
        .rdata (cfg_rdata)
    );

    ap_decode #(
        .HADDR_W(HADDR_W), .MADDR_W(MADDR_W), .GRAN_LOG2(GRAN_LOG2),
        .WIN_LOG2(WIN_LOG2), .WIN_BASE(WIN_BASE), .CTRL_ADDR(CTRL_ADDR)
    ) u_dec (
        .addr  (h_addr),
        .base  (cfg_base),
        .dst   (dec_dst),
        .xaddr (dec_xaddr)
    );

    ap_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .h_valid  (h_valid),
        .dst      (dec_dst),
        .m_ready  (m_ready),
        .m_rvalid (m_rvalid),
        .s_ready  (s_ready),
        .s_rvalid (s_rvalid),
        .h_ready  (h_ready),
        .accept   (accept),
        .ctrl_go  (ctrl_go),
        .m_valid  (m_valid),
        .s_valid  (s_valid),
        .cap_m    (cap_m),
        .cap_s    (cap_s),
        .h_rvalid (h_rvalid)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_write <= 1'b0;
            q_haddr <= '0;
            q_xaddr <= '0;
            q_tgt   <= TGT_VID;
            q_wdata <= '0;
            q_be    <= '0;
        end else if (accept) begin
            q_write <= h_write;
            q_haddr <= h_addr;
            q_xaddr <= dec_xaddr;
            q_tgt   <= cfg_tgt;
            q_wdata <= h_wdata;
            q_be    <= h_be;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       rsp_q <= '0;
        else if (ctrl_go) rsp_q <= cfg_rdata;
        else if (cap_m)   rsp_q <= m_rdata;
        else if (cap_s)   rsp_q <= s_rdata;
    end

    assign h_rdata  = rsp_q;
    assign m_write  = q_write;
    assign m_addr   = q_xaddr;
    assign m_target = q_tgt;
    assign m_wdata  = q_wdata;
    assign m_be     = q_be;
    assign s_write  = q_write;
    assign s_addr   = q_haddr;
    assign s_wdata  = q_wdata;
    assign s_be     = q_be;

endmodule

// File: rtl/ap_xlate_chk.sv
module ap_xlate_chk #(
    parameter int HADDR_W   = 24,
    parameter int MADDR_W   = 40,
    parameter int DW        = 32,
    parameter int GRAN_LOG2 = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               h_ready,
    input logic               h_rvalid,
    input logic [HADDR_W-1:0] h_addr,
    input logic               m_valid,
    input logic               m_ready,
    input logic [MADDR_W-1:0] m_addr,
    input logic [1:0]         m_target,
    input logic [DW-1:0]      m_wdata,
    input logic [DW/8-1:0]    m_be,
    input logic               s_valid,
    input logic               s_ready,
    input logic [HADDR_W-1:0] s_addr,
    input logic [DW-1:0]      s_wdata,
    input logic [DW/8-1:0]    s_be
);
    p_single_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_valid && s_valid));

    p_def_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_valid) |-> s_addr == $past(h_addr));

    p_low_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_valid) |-> m_addr[GRAN_LOG2-1:0] == $past(h_addr[GRAN_LOG2-1:0]));

    p_no_rsvd_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> m_target != 2'd3);

    p_one_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid || s_valid || h_rvalid) |-> !h_ready);

    p_hold_mem_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_target)
                                   && $stable(m_wdata) && $stable(m_be)));

    p_hold_def_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && !s_ready) |=> (s_valid && $stable(s_addr)
                                   && $stable(s_wdata) && $stable(s_be)));
endmodule

bind aperture_xlate ap_xlate_chk #(
    .HADDR_W(HADDR_W), .MADDR_W(MADDR_W), .DW(DW), .GRAN_LOG2(GRAN_LOG2)
) u_chk (
    .clk(clk), .rst_n(rst_n), .h_ready(h_ready), .h_rvalid(h_rvalid),
    .h_addr(h_addr), .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr),
    .m_target(m_target), .m_wdata(m_wdata), .m_be(m_be), .s_valid(s_valid),
    .s_ready(s_ready), .s_addr(s_addr), .s_wdata(s_wdata), .s_be(s_be)
);

// File: tb/aperture_xlate_tb.sv
module aperture_xlate_tb;

    localparam logic [23:0] CTRL = 24'h001700;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_valid = 1'b0, h_write = 1'b0;
    logic [23:0] h_addr = '0;
    logic [31:0] h_wdata = '0;
    logic [3:0]  h_be = '0;
    logic        h_ready, h_rvalid;
    logic [31:0] h_rdata;
    logic        m_valid, m_write, m_ready = 1'b0, m_rvalid = 1'b0;
    logic [39:0] m_addr;
    logic [1:0]  m_target;
    logic [31:0] m_wdata, m_rdata = '0;
    logic [3:0]  m_be;
    logic        s_valid, s_write, s_ready = 1'b0, s_rvalid = 1'b0;
    logic [23:0] s_addr;
    logic [31:0] s_wdata, s_rdata = '0;
    logic [3:0]  s_be;

    always #2.5 clk = ~clk;

    aperture_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_ready(h_ready),
        .h_write(h_write), .h_addr(h_addr), .h_wdata(h_wdata), .h_be(h_be),
        .h_rvalid(h_rvalid), .h_rdata(h_rdata), .m_valid(m_valid),
        .m_ready(m_ready), .m_write(m_write), .m_addr(m_addr),
        .m_target(m_target), .m_wdata(m_wdata), .m_be(m_be),
        .m_rvalid(m_rvalid), .m_rdata(m_rdata), .s_valid(s_valid),
        .s_ready(s_ready), .s_write(s_write), .s_addr(s_addr),
        .s_wdata(s_wdata), .s_be(s_be), .s_rvalid(s_rvalid), .s_rdata(s_rdata)
    );

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] fill(input logic [41:0] key);
        return key[31:0] ^ {22'b0, key[41:32]} ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] be);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[b*8 +: 8] = be[b] ? nw[b*8 +: 8] : old[b*8 +: 8];
        return r;
    endfunction

    // ---------------- port responders (the bench's slave models) ----------------
    logic [31:0] mem_store [logic [41:0]];
    logic [31:0] def_store [logic [41:0]];
    int unsigned stall_cnt = 0;
    int          port_hs = 0;

    always @(posedge clk) begin
        stall_cnt <= stall_cnt + 1;
        m_ready   <= (stall_cnt % 3) != 0;
        s_ready   <= (stall_cnt % 4) != 1;
        m_rvalid  <= 1'b0;
        s_rvalid  <= 1'b0;
        if (m_valid && m_ready) begin
            logic [41:0] k;
            logic [31:0] v;
            k = {m_target, m_addr};
            v = mem_store.exists(k) ? mem_store[k] : fill(k);
            if (m_write) mem_store[k] = merge(v, m_wdata, m_be);
            m_rdata  <= v;
            m_rvalid <= 1'b1;
        end
        if (s_valid && s_ready) begin
            logic [41:0] k;
            logic [31:0] v;
            k = {18'h3_0000, s_addr};
            v = def_store.exists(k) ? def_store[k] : fill(k);
            if (s_write) def_store[k] = merge(v, s_wdata, s_be);
            s_rdata  <= v;
            s_rvalid <= 1'b1;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit          to_mem;
        bit          wr;
        logic [39:0] addr;
        logic [1:0]  tgt;
        logic [31:0] wdata;
        logic [3:0]  be;
        string       req;
    } req_t;

    typedef struct {
        bit          rd;
        logic [31:0] data;
        string       req;
    } rsp_t;

    req_t exp_req[$];
    rsp_t exp_rsp[$];

    logic [31:0] ref_mem [logic [41:0]];
    logic [23:0] sh_base = '0;
    logic [1:0]  sh_tgt  = '0;

    // request monitor
    always @(negedge clk) begin
        if (rst_n && ((m_valid && m_ready) || (s_valid && s_ready))) begin
            port_hs++;
            if (exp_req.size() == 0) begin
                chk(1'b0, "R11 unexpected port request", {23'b0, m_valid, m_addr}, 0);
            end else begin
                req_t e;
                e = exp_req.pop_front();
                if (e.to_mem) begin
                    chk(m_valid, {e.req, " R2 memory port"}, m_valid, 1);
                    chk(m_addr == e.addr, {e.req, " R3 address"}, m_addr, e.addr);
                    chk(m_target == e.tgt, {e.req, " R4 target"}, m_target, e.tgt);
                    chk(m_write == e.wr && m_be == e.be && (!e.wr || m_wdata == e.wdata),
                        {e.req, " R7 wdata/be"}, {m_be, m_wdata}, {e.be, e.wdata});
                end else begin
                    chk(s_valid, {e.req, " R2 default port"}, s_valid, 1);
                    chk(s_addr == e.addr[23:0], {e.req, " R2 default addr"}, s_addr, e.addr);
                    chk(s_write == e.wr && s_be == e.be && (!e.wr || s_wdata == e.wdata),
                        {e.req, " R7 wdata/be"}, {s_be, s_wdata}, {e.be, e.wdata});
                end
            end
        end
    end

    // response monitor
    always @(negedge clk) begin
        if (rst_n && h_rvalid) begin
            if (exp_rsp.size() == 0) begin
                chk(1'b0, "R8 unexpected response", h_rdata, 0);
            end else begin
                rsp_t e;
                e = exp_rsp.pop_front();
                if (e.rd) chk(h_rdata == e.data, {e.req, " R7 read data"}, h_rdata, e.data);
            end
        end
    end

    // ---------------- driver ----------------
    task automatic access(input bit wr, input logic [23:0] a, input logic [31:0] d,
                          input logic [3:0] be, input string req);
        req_t  q;
        rsp_t  r;
        logic [41:0] k;
        int    hs0, wd;
        r.rd = !wr; r.req = req; r.data = '0;
        if (a[23:2] == CTRL[23:2]) begin
            r.data = {6'b0, sh_tgt, sh_base};
            if (wr) begin
                logic [31:0] m;
                m = merge({6'b0, sh_tgt, sh_base}, d, be);
                sh_base = m[23:0];
                if (m[25:24] != 2'd3) sh_tgt = m[25:24];
            end
        end else begin
            q.wr = wr; q.wdata = d; q.be = be; q.req = req;
            if (a[23:20] == 4'h7) begin
                q.to_mem = 1'b1;
                q.addr   = {sh_base, 16'h0} + {20'h0, a[19:0]};
                q.tgt    = sh_tgt;
                k        = {sh_tgt, q.addr};
            end else begin
                q.to_mem = 1'b0;
                q.addr   = {16'h0, a};
                q.tgt    = '0;
                k        = {18'h3_0000, a};
            end
            r.data = ref_mem.exists(k) ? ref_mem[k] : fill(k);
            if (wr) ref_mem[k] = merge(r.data, d, be);
            exp_req.push_back(q);
        end
        exp_rsp.push_back(r);
        hs0 = port_hs;
        @(negedge clk);
        h_valid = 1'b1; h_write = wr; h_addr = a; h_wdata = d; h_be = be;
        while (!h_ready) @(negedge clk);
        @(negedge clk);
        h_valid = 1'b0;
        chk(!h_ready, {req, " R8 busy after accept"}, h_ready, 0);
        wd = 0;
        while (!h_rvalid && wd < 200) begin @(negedge clk); wd++; end
        chk(wd < 200, {req, " watchdog"}, wd, 0);
        @(negedge clk);
        if (a[23:2] == CTRL[23:2])
            chk(port_hs == hs0, {req, " R11 no port traffic"}, port_hs - hs0, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(h_ready && !m_valid && !s_valid, "R1 reset outputs", {h_ready, m_valid, s_valid}, 3'b100);
        access(0, CTRL, 0, 4'hF, "R1 R6 reset readback");
        // R2/R3 base 0, edges of window and default neighbours
        access(0, 24'h700010, 0, 4'hF, "R3 base0 read");
        access(0, 24'h700000, 0, 4'hF, "R2 window low edge");
        access(0, 24'h7FFFFC, 0, 4'hF, "R2 window high edge");
        access(0, 24'h6FFFFC, 0, 4'hF, "R2 below window");
        access(0, 24'h800000, 0, 4'hF, "R2 above window");
        access(1, 24'h000100, 32'hDEAD_BEEF, 4'b0101, "R7 default partial write");
        access(0, 24'h000100, 0, 4'hF, "R7 default readback");
        // R10 move window, coherent target
        access(1, CTRL, 32'h0100_1234, 4'hF, "R10 ctrl move");
        access(0, CTRL, 0, 4'hF, "R6 readback moved");
        access(1, 24'h700020, 32'h1234_5678, 4'hF, "R10 write after move");
        access(0, 24'h700020, 0, 4'hF, "R7 read after move");
        // R5 target 3 keeps target
        access(1, CTRL, 32'h0300_ABCD, 4'hF, "R5 rsvd target write");
        access(0, CTRL, 0, 4'hF, "R5 target kept");
        access(0, 24'h700040, 0, 4'hF, "R5 R4 access after rsvd write");
        // R6 unused bits, byte enables, non-coherent
        access(1, CTRL, 32'hFE00_0042, 4'hF, "R6 unused bits");
        access(0, CTRL, 0, 4'hF, "R6 unused read zero");
        access(1, CTRL, 32'h0000_00EE, 4'b0001, "R6 byte enable");
        access(0, CTRL, 0, 4'hF, "R6 byte enable readback");
        access(0, 24'h7ABCDC, 0, 4'hF, "R4 noncoherent access");
        // R3 highest boundary and wrap
        access(1, CTRL, 32'h00FF_FFFF, 4'hF, "R3 top base");
        access(0, 24'h700000, 0, 4'hF, "R3 top base offset0");
        access(1, 24'h70FFFC, 32'hCAFE_F00D, 4'b1100, "R3 top of space write");
        access(0, 24'h70FFFC, 0, 4'hF, "R3 top of space read");
        access(0, 24'h710000, 0, 4'hF, "R3 wrap to zero");
        // R4 same address, other target is a distinct location
        access(1, CTRL, 32'h0200_0000, 4'hF, "R4 target 2 base 0");
        access(1, 24'h700010, 32'h0BAD_CAFE, 4'hF, "R4 write ncoh");
        access(1, CTRL, 32'h0000_0000, 4'hF, "R4 back to video");
        access(0, 24'h700010, 0, 4'hF, "R4 video untouched");
        repeat (5) @(negedge clk);
        chk(exp_req.size() == 0 && exp_rsp.size() == 0, "R8 scoreboard drained",
            exp_req.size() + exp_rsp.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule